// File: doc/BRIEF.md
# Clock Output Conditioning Stage

This block sits between a source clock and one output pad. It divides the source clock by a programmable power of two, can invert the result, and either drives the result onto the pad or parks the pad in a chosen idle state: held low, held high, or released to high impedance. An output-enable signal goes to the tristate pad so that the park-to-float state can be realised.

A small set of registered settings decides which configuration is live: ratio, invert, enable and idle code. These settings are sampled only at the end of a complete divided period, so a change never cuts a pulse short. When the output is switched on, the divider counter starts at a programmed offset. This gives a coarse phase shift measured in source-clock cycles.

Top module: `clkout_stage`

## Requirements
- R1: With exponent n (1 to 7), the output period is 2^n source cycles. The output is high for the first 2^(n-1) cycles of each period (counter values 0 to 2^(n-1)-1) and low for the rest, before inversion.
- R2: An exponent of 0 gives the same output as an exponent of 1, which is divide-by-2.
- R3: A change of the enable input takes effect only at the edge that ends a period, when the counter holds its last value 2^n-1. The first setting is also taken at the first edge after reset release. A period that has started while enabled is always completed.
- R4: When disabled, idle code 2'b00 gives clk_o=0 with oe_o=1. Code 2'b01 gives clk_o=1 with oe_o=1. Code 2'b10 gives oe_o=0 with clk_o=0. Code 2'b11 behaves as 2'b00. The idle code is sampled at the same edges as the enable.
- R5: When the invert bit is 1, the divided clock is inverted before it reaches clk_o. The bit is sampled at the period-end edges and has no effect while the output is parked.
- R6: A new exponent is taken at the period-end edge. The next period, which starts high, uses the new ratio.
- R7: At the edge where the output turns on (enable goes from off to on, including the first edge after reset), the counter loads phase_i modulo 2^n of the new ratio instead of 0. Otherwise a period end reloads 0.
- R8: While reset is asserted, clk_o=0 and oe_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_exp_i | input | EXP_W (3) | Divider exponent n; ratio 2^n |
| invert_i | input | 1 | Invert the divided clock |
| enable_i | input | 1 | Request the output to be driven |
| park_sel_i | input | 2 | Idle state code used when disabled |
| phase_i | input | PH_W (7) | Start offset in source cycles |
| clk_o | output | 1 | Conditioned clock value for the pad |
| oe_o | output | 1 | Pad output enable; 0 floats the pad |

## Verification
The bench builds the block with the default parameters: a 3-bit exponent and a 7-bit phase. With these values every exponent from 0 to 7 can be tested, including the reserved 0, and the largest ratio of 128. The phase input can reach 127, so offsets can be tested both inside and beyond the active ratio, where the modulo wrap matters. A behavioural model predicts clk_o and oe_o on every cycle. It is exercised across all ratios, all idle codes, inversion, and enable and exponent changes made in the middle of a period.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

   typedef enum logic [1:0] {
      PARK_LOW  = 2'b00,
      PARK_HIGH = 2'b01,
      PARK_HIZ  = 2'b10,
      PARK_RSVD = 2'b11
   } park_t;

endpackage

// File: rtl/clkout_divider.sv
module clkout_divider #(
   parameter int EXP_W = 3,
   parameter int PH_W  = 7,
   localparam int MAX_EXP = (1 << EXP_W) - 1,
   localparam int CNT_W   = MAX_EXP
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [EXP_W-1:0] act_exp_i,
   input  logic [EXP_W-1:0] nxt_exp_i,
   input  logic             reload_i,
   input  logic [PH_W-1:0]  phase_i,
   output logic             started_o,
   output logic             load_o,
   output logic             div_o,
   output logic [CNT_W-1:0] cnt_o
);

   function automatic logic [CNT_W-1:0] last_count(input logic [EXP_W-1:0] e);
      logic [CNT_W:0] t;
      t = ({{CNT_W{1'b0}}, 1'b1} << e) - 1'b1;
      return t[CNT_W-1:0];
   endfunction

   logic [CNT_W-1:0] cnt_q;
   logic             started_q;
   logic             wrap;
   logic [CNT_W-1:0] ph_ext;
   logic [CNT_W-1:0] seed;
   logic [MAX_EXP:0] taps;

   // fit the phase word to the counter width
   generate
      if (PH_W >= CNT_W) begin : g_ph_trunc
         assign ph_ext = phase_i[CNT_W-1:0];
      end else begin : g_ph_ext
         assign ph_ext = {{(CNT_W-PH_W){1'b0}}, phase_i};
      end
   endgenerate

   assign wrap   = started_q && (cnt_q == last_count(act_exp_i));
   assign load_o = !started_q || wrap;
   assign seed   = reload_i ? (ph_ext & last_count(nxt_exp_i)) : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q     <= '0;
         started_q <= 1'b0;
      end else begin
         started_q <= 1'b1;
         cnt_q     <= load_o ? seed : cnt_q + 1'b1;
      end
   end

   // one tap per ratio: high in the first half of each period
   assign taps[0] = ~cnt_q[0];
   generate
      for (genvar i = 1; i <= MAX_EXP; i++) begin : g_tap
         assign taps[i] = ~cnt_q[i-1];
      end
   endgenerate

   assign div_o     = taps[act_exp_i];
   assign started_o = started_q;
   assign cnt_o     = cnt_q;

   p_cnt_in_range_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      started_q |-> ((cnt_q & ~last_count(act_exp_i)) == '0));

   p_cnt_step_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (started_q && $past(started_q) && !$past(load_o)) |-> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
   import clkout_pkg::*;
#(
   parameter int EXP_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [EXP_W-1:0] div_exp_i,
   input  logic             invert_i,
   input  logic             enable_i,
   input  logic [1:0]       park_sel_i,
   output logic [EXP_W-1:0] act_exp_o,
   output logic [EXP_W-1:0] nxt_exp_o,
   output logic             act_en_o,
   output logic             act_inv_o,
   output park_t            park_o,
   output logic             reload_o
);

   logic [EXP_W-1:0] exp_q;
   logic             en_q;
   logic             inv_q;
   park_t            park_q;

   // exponent 0 is folded onto the minimum ratio
   assign nxt_exp_o = (div_exp_i == '0) ? EXP_W'(1) : div_exp_i;
   assign reload_o  = enable_i && !en_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         exp_q  <= EXP_W'(1);
         en_q   <= 1'b0;
         inv_q  <= 1'b0;
         park_q <= PARK_LOW;
      end else if (load_i) begin
         exp_q  <= nxt_exp_o;
         en_q   <= enable_i;
         inv_q  <= invert_i;
         park_q <= park_t'(park_sel_i);
      end
   end

   assign act_exp_o = exp_q;
   assign act_en_o  = en_q;
   assign act_inv_o = inv_q;
   assign park_o    = park_q;

   p_cfg_hold_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(load_i) |-> ($stable(en_q) && $stable(exp_q) && $stable(inv_q) && $stable(park_q)));

endmodule

// File: rtl/clkout_park.sv
module clkout_park
   import clkout_pkg::*;
(
   input  logic  en_i,
   input  logic  inv_i,
   input  logic  div_i,
   input  park_t park_i,
   output logic  clk_o,
   output logic  oe_o
);

   always_comb begin
      if (en_i) begin
         clk_o = div_i ^ inv_i;
         oe_o  = 1'b1;
      end else begin
         unique case (park_i)
            PARK_HIGH: begin clk_o = 1'b1; oe_o = 1'b1; end
            PARK_HIZ:  begin clk_o = 1'b0; oe_o = 1'b0; end
            default:   begin clk_o = 1'b0; oe_o = 1'b1; end
         endcase
      end
   end

endmodule

// File: rtl/clkout_stage.sv
module clkout_stage
   import clkout_pkg::*;
#(
   parameter int EXP_W = 3,
   parameter int PH_W  = 7
) (
   input  logic             clk_src_i,
   input  logic             rst_ni,
   input  logic [EXP_W-1:0] div_exp_i,
   input  logic             invert_i,
   input  logic             enable_i,
   input  logic [1:0]       park_sel_i,
   input  logic [PH_W-1:0]  phase_i,
   output logic             clk_o,
   output logic             oe_o
);

   localparam int MAX_EXP = (1 << EXP_W) - 1;
   localparam int CNT_W   = MAX_EXP;

   generate
      if (EXP_W < 1 || EXP_W > 4) begin : g_bad_exp
         $error("clkout_stage: EXP_W must lie in 1..4");
      end
      if (PH_W < 1) begin : g_bad_ph
         $error("clkout_stage: PH_W must be positive");
      end
   endgenerate

   logic [EXP_W-1:0] act_exp_w;
   logic [EXP_W-1:0] nxt_exp_w;
   logic             act_en_w;
   logic             act_inv_w;
   park_t            park_w;
   logic             reload_w;
   logic             started_w;
   logic             load_w;
   logic             div_w;
   logic [CNT_W-1:0] cnt_w;

   clkout_ctrl #(.EXP_W(EXP_W)) i_ctrl (
      .clk_i      (clk_src_i),
      .rst_ni     (rst_ni),
      .load_i     (load_w),
      .div_exp_i  (div_exp_i),
      .invert_i   (invert_i),
      .enable_i   (enable_i),
      .park_sel_i (park_sel_i),
      .act_exp_o  (act_exp_w),
      .nxt_exp_o  (nxt_exp_w),
      .act_en_o   (act_en_w),
      .act_inv_o  (act_inv_w),
      .park_o     (park_w),
      .reload_o   (reload_w)
   );

   clkout_divider #(.EXP_W(EXP_W), .PH_W(PH_W)) i_div (
      .clk_i     (clk_src_i),
      .rst_ni    (rst_ni),
      .act_exp_i (act_exp_w),
      .nxt_exp_i (nxt_exp_w),
      .reload_i  (reload_w),
      .phase_i   (phase_i),
      .started_o (started_w),
      .load_o    (load_w),
      .div_o     (div_w),
      .cnt_o     (cnt_w)
   );

   clkout_park i_park (
      .en_i   (act_en_w),
      .inv_i  (act_inv_w),
      .div_i  (div_w),
      .park_i (park_w),
      .clk_o  (clk_o),
      .oe_o   (oe_o)
   );

   p_off_at_wrap_r3 : assert property (@(posedge clk_src_i) disable iff (!rst_ni)
      $fell(act_en_w) |-> (cnt_w == '0));

   p_period_starts_high_r1 : assert property (@(posedge clk_src_i) disable iff (!rst_ni)
      ($past(load_w) && $past(started_w) && $past(act_en_w) && act_en_w)
         |-> (clk_o == !act_inv_w && oe_o));

endmodule

// File: tb/test_clkout_stage.sv
module test_clkout_stage;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] exp_s = 3'd1;
   logic       inv_s = 1'b0;
   logic       en_s = 1'b0;
   logic [1:0] park_s = 2'b00;
   logic [6:0] ph_s = 7'd0;
   logic       clk_o;
   logic       oe_o;

   int    total = 0;
   int    bad = 0;
   int    cycles = 0;
   string tag = "R1";

   // reference model state
   int m_cnt = 0, m_exp = 1, m_en = 0, m_inv = 0, m_park = 0, m_started = 0;

   always #5 clk = ~clk;

   clkout_stage i_clkout_stage (
      .clk_src_i  (clk),
      .rst_ni     (rst_n),
      .div_exp_i  (exp_s),
      .invert_i   (inv_s),
      .enable_i   (en_s),
      .park_sel_i (park_s),
      .phase_i    (ph_s),
      .clk_o      (clk_o),
      .oe_o       (oe_o)
   );

   function automatic int fold(int e);
      return (e == 0) ? 1 : e;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_exp = 1; m_en = 0; m_inv = 0; m_park = 0; m_started = 0;
      end else if (m_started == 0 || m_cnt == (1 << m_exp) - 1) begin
         int ne;
         ne = fold(int'(exp_s));
         m_cnt = (en_s && m_en == 0) ? (int'(ph_s) % (1 << ne)) : 0;
         m_exp = ne; m_en = int'(en_s); m_inv = int'(inv_s);
         m_park = int'(park_s); m_started = 1;
      end else begin
         m_cnt = m_cnt + 1;
      end
   end

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(negedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         bad++;
         total++;
         $display("FAIL watchdog expired tag=%s", tag);
         finish_run();
      end
      if (rst_n) begin
         logic ec, eo;
         if (m_en != 0) begin
            ec = ((m_cnt < (1 << (m_exp - 1))) ? 1'b1 : 1'b0) ^ m_inv[0];
            eo = 1'b1;
         end else begin
            ec = (m_park == 1);
            eo = (m_park != 2);
         end
         total++;
         if (clk_o !== ec || oe_o !== eo) begin
            bad++;
            $display("FAIL %s cycle %0d: clk_o=%b oe_o=%b expected clk_o=%b oe_o=%b",
                     tag, cycles, clk_o, oe_o, ec, eo);
         end
      end
   end

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      // R8: reset state
      run(3);
      total++;
      if (clk_o !== 1'b0 || oe_o !== 1'b1) begin
         bad++;
         $display("FAIL R8 reset: clk_o=%b oe_o=%b expected 0 1", clk_o, oe_o);
      end
      en_s = 1'b1; exp_s = 3'd3; ph_s = 7'd0;
      rst_n = 1'b1;
      // R1: every ratio
      tag = "R1";
      for (int n = 1; n <= 7; n++) begin
         exp_s = 3'(n);
         run(300);
      end
      // R2: exponent 0 acts as divide-by-2
      tag = "R2";
      exp_s = 3'd0; run(40);
      // R5: inversion
      tag = "R5";
      exp_s = 3'd2; inv_s = 1'b1; run(30);
      exp_s = 3'd5; run(100);
      inv_s = 1'b0; run(70);
      // R6: ratio change mid period
      tag = "R6";
      exp_s = 3'd4; run(7);
      exp_s = 3'd2; run(3);
      exp_s = 3'd6; run(150);
      // R3: enable toggles mid period
      tag = "R3";
      exp_s = 3'd4; run(40);
      run(5); en_s = 1'b0; run(3); en_s = 1'b1; run(40);
      run(3); en_s = 1'b0; run(50);
      // R4: each idle code, changed mid period while parked
      tag = "R4";
      for (int c = 0; c < 4; c++) begin
         park_s = 2'(c); run(37);
      end
      park_s = 2'b10; run(20);
      // R5: invert while parked has no visible effect
      tag = "R5";
      inv_s = 1'b1; run(40); inv_s = 1'b0;
      // R7: phase offset on turn-on, including wrap past the ratio
      tag = "R7";
      exp_s = 3'd3; ph_s = 7'd5; en_s = 1'b1; run(40);
      en_s = 1'b0; run(20);
      ph_s = 7'd127; exp_s = 3'd7; en_s = 1'b1; run(300);
      en_s = 1'b0; run(140);
      ph_s = 7'd13; exp_s = 3'd2; en_s = 1'b1; run(30);
      // R7: phase after reset release
      rst_n = 1'b0; run(2);
      total++;
      if (clk_o !== 1'b0 || oe_o !== 1'b1) begin
         bad++;
         $display("FAIL R8 second reset: clk_o=%b oe_o=%b expected 0 1", clk_o, oe_o);
      end
      exp_s = 3'd4; ph_s = 7'd9; en_s = 1'b1;
      rst_n = 1'b1; run(60);
      finish_run();
   end

endmodule